// File: doc/BRIEF.md
# DRAM Read Address Decoder and Wrapped Burst Sequencer

This block takes a byte-addressed 32-bit physical read request and turns it into a stream of per-beat DRAM locations. The memory behind it is 64 bits wide and built from four-bank devices. The address splits into fixed fields. Bits 2:0 choose a byte inside the 64-bit word. Bits 11:3 give a 9-bit column. Bits 13:12 give a 2-bit bank. Bits 26:14 give a 13-bit row. Bits 28:27 give a 2-bit rank. Bits 31:29 are not used. For example, 0x0AC75C38 resolves to rank 1, bank 1, row 0x0B1D, column 0x187.

Each accepted request produces a burst of 1, 2, 4 or 8 beats. A 32-byte line uses 4 beats and a 64-byte line uses 8. The first beat carries the column that holds the requested word. The following beats step upward through the column and wrap inside the burst-aligned group, so only the low log2(n) column bits change. Every beat also carries the rank, bank and row, plus a flag that marks the final beat.

Both sides are valid/ready streams. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while no burst is in flight, so the next request can be accepted on the cycle after the final beat is taken. A beat is consumed on a cycle where `beat_valid` and `beat_ready` are both high. While `beat_ready` is low, the current beat and all of its fields hold still.

Top module: `dram_burst_seq`

## Requirements
- R1: An accepted address is split as follows: rank = bits 28:27, bank = bits 13:12, row = bits 26:14, column = bits 11:3. For example, 0x0AC75C38 gives rank 1, bank 1, row 0x0B1D, column 0x187.
- R2: Address bits 31:29 have no effect on any beat output.
- R3: `burst_sel` encodes the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. Exactly that many beats are emitted for each accepted request.
- R4: The first beat of a burst carries the column taken from the requested address.
- R5: Each later beat carries the previous column plus one, taken modulo n inside the n-aligned group. The column bits at and above bit log2(n) do not change during the burst. For example, column 0x187 with n = 4 gives 0x187, 0x184, 0x185, 0x186.
- R6: Address bits 2:0 have no effect on any beat output.
- R7: `req_ready` is low while a burst is in progress. A request presented during a burst is not accepted and produces no beats.
- R8: `beat_last` is high on the final beat of a burst and low on every other beat. After the final beat is taken, `beat_valid` falls on the next cycle.
- R9: While `beat_valid` is high and `beat_ready` is low, `beat_valid` and all beat fields stay unchanged on the next cycle.
- R10: After synchronous active-high reset, including a reset in the middle of a burst, `beat_valid` is low and `req_ready` is high.
- R11: The burst length is captured when a request is accepted. Changing `burst_sel` during a burst does not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| burst_sel | input | 2 | Burst length code (0:1, 1:2, 2:4, 3:8 beats) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (high when idle) |
| req_addr | input | 32 | Byte physical address |
| beat_valid | output | 1 | Beat valid |
| beat_ready | input | 1 | Beat consumer ready |
| beat_rank | output | 2 | Rank of the current beat |
| beat_bank | output | 2 | Bank of the current beat |
| beat_row | output | 13 | Row of the current beat |
| beat_col | output | 9 | Column of the current beat |
| beat_last | output | 1 | Final beat of the burst |

## Verification
Two things can land in the same cycle: the consumer taking the final beat, and a new request waiting at the input. The bench provokes this by holding a second request valid for the whole of a burst and dropping it before the final beat is taken. It then judges two points: `req_ready` must stay low through that final beat, and no extra beat may appear afterwards. The bench also stalls the consumer on a mid-burst beat and changes `burst_sel` right after acceptance. In both cases it checks that the column sequence and the beat count are unchanged.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  localparam int ADDR_W   = 32;
  localparam int COL_LSB  = 3;
  localparam int COL_W    = 9;
  localparam int BANK_LSB = COL_LSB + COL_W;
  localparam int BANK_W   = 2;
  localparam int ROW_LSB  = BANK_LSB + BANK_W;
  localparam int ROW_W    = 13;
  localparam int RANK_LSB = ROW_LSB + ROW_W;
  localparam int RANK_W   = 2;
  localparam int SEL_W    = 2;
  localparam int MAX_LOG  = 3;
  localparam int CNT_W    = MAX_LOG;

  typedef struct packed {
    logic [RANK_W-1:0] rank;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } dram_loc_t;
endpackage

// File: rtl/dseq_addr_split.sv
module dseq_addr_split
  import dram_seq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output dram_loc_t         loc
);
  // R1: fixed field extraction; R2/R6: unused upper and byte-offset bits dropped
  always_comb begin
    loc.rank = addr[RANK_LSB +: RANK_W];
    loc.bank = addr[BANK_LSB +: BANK_W];
    loc.row  = addr[ROW_LSB  +: ROW_W];
    loc.col  = addr[COL_LSB  +: COL_W];
  end
endmodule

// File: rtl/dseq_col_step.sv
module dseq_col_step #(
  parameter int COL_W = 9,
  parameter int SEL_W = 2
) (
  input  logic [COL_W-1:0] col_in,
  input  logic [SEL_W-1:0] len_log,
  output logic [COL_W-1:0] col_out
);
  logic [COL_W-1:0] col_inc;
  assign col_inc = col_in + 1'b1;

  // R5: bits below len_log take the incremented value, the rest hold
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col_out[i] = (i < int'(len_log)) ? col_inc[i] : col_in[i];
  end
endmodule

// File: rtl/dseq_burst_ctrl.sv
module dseq_burst_ctrl #(
  parameter int SEL_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             beat_ready,
  output logic             req_ready,
  output logic             accept,
  output logic             beat_valid,
  output logic             beat_last,
  output logic             advance,
  output logic [SEL_W-1:0] len_log
);
  typedef enum logic {ST_IDLE, ST_BURST} st_t;

  st_t             state;
  logic [CNT_W-1:0] beat_cnt;
  logic [CNT_W-1:0] last_idx;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign beat_valid = (state == ST_BURST);
  assign last_idx   = CNT_W'((1 << len_log) - 1);
  assign beat_last  = beat_valid && (beat_cnt == last_idx);
  assign advance    = beat_valid && beat_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      beat_cnt <= '0;
      len_log  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_BURST;
          beat_cnt <= '0;
          len_log  <= sel_in;   // R11: length captured at acceptance
        end
        ST_BURST: if (advance) begin
          if (beat_last) state <= ST_IDLE;
          else           beat_cnt <= beat_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_burst_seq.sv
module dram_burst_seq
  import dram_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  burst_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [RANK_W-1:0] beat_rank,
  output logic [BANK_W-1:0] beat_bank,
  output logic [ROW_W-1:0]  beat_row,
  output logic [COL_W-1:0]  beat_col,
  output logic              beat_last
);
  dram_loc_t        dec_loc;
  dram_loc_t        cur_loc;
  logic [COL_W-1:0] next_col;
  logic             accept;
  logic             advance;
  logic [SEL_W-1:0] len_log;

  dseq_addr_split u_split (
    .addr (req_addr),
    .loc  (dec_loc)
  );

  dseq_burst_ctrl #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .sel_in     (burst_sel),
    .beat_ready (beat_ready),
    .req_ready  (req_ready),
    .accept     (accept),
    .beat_valid (beat_valid),
    .beat_last  (beat_last),
    .advance    (advance),
    .len_log    (len_log)
  );

  dseq_col_step #(.COL_W(COL_W), .SEL_W(SEL_W)) u_step (
    .col_in  (cur_loc.col),
    .len_log (len_log),
    .col_out (next_col)
  );

  // R4: location loads on acceptance; column steps on each non-final handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_loc <= '0;
    end else if (accept) begin
      cur_loc <= dec_loc;
    end else if (advance && !beat_last) begin
      cur_loc.col <= next_col;
    end
  end

  assign beat_rank = cur_loc.rank;
  assign beat_bank = cur_loc.bank;
  assign beat_row  = cur_loc.row;
  assign beat_col  = cur_loc.col;
endmodule

// File: rtl/dseq_checker.sv
module dseq_checker (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  burst_sel,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        beat_valid,
  input logic        beat_ready,
  input logic [1:0]  beat_rank,
  input logic [1:0]  beat_bank,
  input logic [12:0] beat_row,
  input logic [8:0]  beat_col,
  input logic        beat_last
);
  p_split_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (beat_rank == $past(req_addr[28:27]) &&
                                  beat_bank == $past(req_addr[13:12]) &&
                                  beat_row  == $past(req_addr[26:14])));

  p_first_col_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (beat_valid && beat_col == $past(req_addr[11:3])));

  p_group_r5: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && !beat_last) |=>
      (beat_valid && beat_col[8:3] == $past(beat_col[8:3])));

  p_busy_r7: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> !req_ready);

  p_last_r8: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && beat_last) |=> !beat_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_col) &&
      $stable(beat_row) && $stable(beat_bank) && $stable(beat_rank) &&
      $stable(beat_last)));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!beat_valid && req_ready));
endmodule

bind dram_burst_seq dseq_checker u_chk (.*);

// File: tb/dram_burst_seq_tb.sv
`timescale 1ns/1ps
module dram_burst_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  burst_sel = 2'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        beat_valid;
  logic        beat_ready = 1'b1;
  logic [1:0]  beat_rank;
  logic [1:0]  beat_bank;
  logic [12:0] beat_row;
  logic [8:0]  beat_col;
  logic        beat_last;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dram_burst_seq u_dut (.*);

  localparam int NV = 7;
  localparam logic [31:0] V_ADDR [NV] = '{32'h0AC7_5C38, 32'hEAC7_5C38, 32'h0000_0000,
    32'h1FFF_FFFF, 32'h0000_1007, 32'h0800_4010, 32'hE000_0005};
  localparam logic [1:0]  V_SEL  [NV] = '{2'd2, 2'd3, 2'd0, 2'd3, 2'd1, 2'd2, 2'd0};
  localparam logic [1:0]  V_RANK [NV] = '{2'd1, 2'd1, 2'd0, 2'd3, 2'd0, 2'd1, 2'd0};
  localparam logic [1:0]  V_BANK [NV] = '{2'd1, 2'd1, 2'd0, 2'd3, 2'd1, 2'd0, 2'd0};
  localparam logic [12:0] V_ROW  [NV] = '{13'h0B1D, 13'h0B1D, 13'h0, 13'h1FFF, 13'h0, 13'h1, 13'h0};
  localparam logic [8:0]  V_COL  [NV] = '{9'h187, 9'h187, 9'h0, 9'h1FF, 9'h0, 9'h2, 9'h0};

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // mode: 0 plain, 1 change burst_sel after accept (R11), 2 intruding request (R7), 3 stall beat1 (R9)
  task automatic run_burst(logic [31:0] a, logic [1:0] sel, logic [1:0] rk, logic [1:0] bk,
                           logic [12:0] rw, logic [8:0] c0, int mode);
    int n = 1 << sel;
    int base = int'(c0) - (int'(c0) % n);
    @(negedge clk);
    burst_sel = sel; req_addr = a; req_valid = 1'b1;
    chk("R10 ready before request", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (mode == 1) burst_sel = ~sel;
    for (int i = 0; i < n; i++) begin
      int ec = base + ((int'(c0) % n + i) % n);
      if (mode == 2 && i == 0) begin req_valid = 1'b1; req_addr = 32'h0123_4567; end
      if (mode == 2 && i == n - 1) req_valid = 1'b0;
      chk("R3 beat valid", int'(beat_valid), 1);
      chk("R1/R2/R6 rank", int'(beat_rank), int'(rk));
      chk("R1/R2/R6 bank", int'(beat_bank), int'(bk));
      chk("R1/R2/R6 row", int'(beat_row), int'(rw));
      chk(i == 0 ? "R4 first column" : "R5 wrapped column", int'(beat_col), ec);
      chk("R8 last flag", int'(beat_last), (i == n - 1) ? 1 : 0);
      chk("R7 not ready while busy", int'(req_ready), 0);
      if (mode == 3 && i == 1) begin
        beat_ready = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 held valid", int'(beat_valid), 1);
        chk("R9 held column", int'(beat_col), ec);
        chk("R9 held last", int'(beat_last), (i == n - 1) ? 1 : 0);
        beat_ready = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
    end
    chk("R8 valid drops after last", int'(beat_valid), 0);
    chk("R3 idle after n beats", int'(req_ready), 1);
    burst_sel = sel;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset beat_valid", int'(beat_valid), 0);
    chk("R10 reset req_ready", int'(req_ready), 1);
    rst = 1'b0;

    for (int v = 0; v < NV; v++)
      run_burst(V_ADDR[v], V_SEL[v], V_RANK[v], V_BANK[v], V_ROW[v], V_COL[v], 0);

    // R11: length held although burst_sel changes mid-burst
    run_burst(32'h0AC7_5C38, 2'd3, 2'd1, 2'd1, 13'h0B1D, 9'h187, 1);
    // R7: request held during a burst and dropped before the final beat
    run_burst(32'h0800_4010, 2'd2, 2'd1, 2'd0, 13'h1, 9'h2, 2);
    @(negedge clk);
    chk("R7 intruding request made no beats", int'(beat_valid), 0);
    // R9: consumer stall on a middle beat
    run_burst(32'h1FFF_FFFF, 2'd3, 2'd3, 2'd3, 13'h1FFF, 9'h1FF, 3);
    // R6: byte offset ignored (same location as vector 0, offset 7)
    run_burst(32'h0AC7_5C3F, 2'd1, 2'd1, 2'd1, 13'h0B1D, 9'h187, 0);

    // R10: reset in the middle of a burst
    @(negedge clk);
    burst_sel = 2'd3; req_addr = 32'h0000_0100; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 burst started", int'(beat_valid), 1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R10 mid-burst reset beat_valid", int'(beat_valid), 0);
    chk("R10 mid-burst reset req_ready", int'(req_ready), 1);
    @(negedge clk);
    chk("R10 stays idle", int'(beat_valid), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule